// File: doc/BRIEF.md
# Double-Buffered PWM Timer with Gated Reload

An up-counting PWM timer whose modulus, start value and eight per-channel compare thresholds are double-buffered. A register port writes only into shadow copies. The counter and the compare logic act only on the active copies. The active copies are refreshed from the shadows in one clock edge, at a synchronization point, and only while a one-shot reload-enable flag is set.

A synchronization point is either the counter leaving its modulus value or a compare hit on a channel that software has marked as a reload source. After a reload the flag clears by itself. Software therefore prepares a full new set of values and then arms exactly one coherent update.

Each channel produces a one-cycle equality indication and an edge-aligned PWM level. The level is high while the counter is below the channel threshold.

Top module: `pwm_reload_ctrl`

## Requirements
- R1: After reset the counter, all shadow registers, all active registers and the reload-control register are 0.
- R2: On each clock the counter increments by one. In a cycle where it equals the active modulus it loads the active start value instead.
- R3: The register port has word addresses: modulus at 0, start value at 1, and channel j threshold at 8+j. Writes land in the shadow copy (low 16 bits kept). Reads return the shadow copy, and unmapped addresses read 0.
- R4: The reload-control register at address 2 holds the reload-source mask for channels 0..7 in bits 7:0 and the reload enable in bit 9. Bit 8 and bits 31:10 always read 0.
- R5: While the reload enable is 0, shadow writes do not change the counter sequence or the outputs.
- R6: With the enable set, the clock edge at which the counter equals the active modulus copies every shadow register into its active register. The counter reload in that edge uses the old start value.
- R7: With the enable set, a channel whose mask bit is 1 and whose counter equals its active threshold also causes the copy at that edge.
- R8: A compare hit on a channel whose mask bit is 0 causes no copy.
- R9: A copy clears the enable bit in the same edge and leaves the mask bits unchanged. A wrap and a selected hit in the same cycle perform a single copy.
- R10: match_o[j] is 1 when the counter equals channel j's active threshold. pwm_o[j] is 1 while the counter is below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| cnt_o | output | 16 | Current counter value |
| match_o | output | 8 | Per-channel equality with active threshold |
| pwm_o | output | 8 | Per-channel edge-aligned PWM level |

## Verification
Faults in the active registers do not show up on rdata_o, because reads return shadow values. They show up on cnt_o within one counter period: the value at which the counter turns back, or the value it restarts from, moves. They also show up on match_o and pwm_o in the first cycle the counter reaches the affected threshold. A stuck or wrongly cleared reload enable appears on the next read of the control register, one cycle after the synchronization point. The bench therefore places every reload at a known counter value and then follows the counter through a full period to confirm which modulus took effect.

// File: rtl/pwm_reload_pkg.sv
`timescale 1ns/1ps
package pwm_reload_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_MOD  = 0;
  localparam int unsigned ADDR_INIT = 1;
  localparam int unsigned ADDR_LOAD = 2;
  localparam int unsigned LD_EN_BIT = 9;
endpackage

// File: rtl/pwm_load_trig.sv
`timescale 1ns/1ps
module pwm_load_trig #(
  parameter int unsigned N_CH = 8
) (
  input  logic            en_i,
  input  logic            wrap_i,
  input  logic [N_CH-1:0] match_i,
  input  logic [N_CH-1:0] sel_i,
  output logic            load_o
);
  logic sync_pt;

  assign sync_pt = wrap_i | (|(match_i & sel_i));
  assign load_o  = en_i & sync_pt;

  always_comb begin
    a_r5_load_needs_en: assert (!load_o || en_i);
    // R8: a hit on a masked-out channel alone never loads
    a_r8_masked_hit: assert (!(load_o && !wrap_i && ((match_i & sel_i) == '0)));
  end
endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] mod_buf_i,
  input  logic [CNT_W-1:0] init_buf_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] mod_q, init_q;

  assign wrap_o = (cnt_o == mod_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      mod_q  <= '0;
      init_q <= '0;
    end else begin
      cnt_o <= wrap_o ? init_q : cnt_o + CNT_W'(1);
      if (load_i) begin
        mod_q  <= mod_buf_i;
        init_q <= init_buf_i;
      end
    end
  end

  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_o == $past(init_q));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> cnt_o == $past(cnt_o) + CNT_W'(1));
  a_r5_hold_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mod_q) && $stable(init_q));
  a_r6_take_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> mod_q == $past(mod_buf_i) && init_q == $past(init_buf_i));
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cv_buf_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             match_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] cv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cv_q <= '0;
    else if (load_i) cv_q <= cv_buf_i;
  end

  assign match_o = (cnt_i == cv_q);
  assign pwm_o   = (cnt_i < cv_q);

  a_r10_low_at_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> !pwm_o);
  a_r5_cv_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(cv_q));
endmodule

// File: rtl/pwm_shadow_regs.sv
`timescale 1ns/1ps
module pwm_shadow_regs
  import pwm_reload_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = $clog2(N_CH) + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic                        load_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [CNT_W-1:0]            mod_buf_o,
  output logic [CNT_W-1:0]            init_buf_o,
  output logic [N_CH-1:0][CNT_W-1:0]  cv_buf_o,
  output logic [N_CH-1:0]             sel_o,
  output logic                        en_o
);
  localparam int unsigned CH_W = $clog2(N_CH);

  logic wr_mod, wr_init, wr_load, cv_region;
  logic [CH_W-1:0] cv_idx;

  assign cv_region = addr_i[ADDR_W-1];
  assign cv_idx    = addr_i[CH_W-1:0];
  assign wr_mod    = we_i && addr_i == ADDR_W'(ADDR_MOD);
  assign wr_init   = we_i && addr_i == ADDR_W'(ADDR_INIT);
  assign wr_load   = we_i && addr_i == ADDR_W'(ADDR_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mod_buf_o  <= '0;
      init_buf_o <= '0;
      sel_o      <= '0;
      en_o       <= 1'b0;
    end else begin
      if (wr_mod)  mod_buf_o  <= wdata_i[CNT_W-1:0];
      if (wr_init) init_buf_o <= wdata_i[CNT_W-1:0];
      // software write wins over the hardware clear
      if (wr_load) begin
        sel_o <= wdata_i[N_CH-1:0];
        en_o  <= wdata_i[LD_EN_BIT];
      end else if (load_i) begin
        en_o  <= 1'b0;
      end
    end
  end

  for (genvar j = 0; j < N_CH; j++) begin : g_cv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cv_buf_o[j] <= '0;
      else if (we_i && cv_region && cv_idx == CH_W'(j))
        cv_buf_o[j] <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (cv_region)
      rdata_o[CNT_W-1:0] = cv_buf_o[cv_idx];
    else if (addr_i == ADDR_W'(ADDR_MOD))
      rdata_o[CNT_W-1:0] = mod_buf_o;
    else if (addr_i == ADDR_W'(ADDR_INIT))
      rdata_o[CNT_W-1:0] = init_buf_o;
    else if (addr_i == ADDR_W'(ADDR_LOAD)) begin
      rdata_o[N_CH-1:0]  = sel_o;
      rdata_o[LD_EN_BIT] = en_o;
    end
  end

  a_r9_en_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_load) |=> !en_o);
  a_r9_sel_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_load |=> $stable(sel_o));
  a_r4_no_arm_by_hw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_load && !en_o) |=> !en_o);
endmodule

// File: rtl/pwm_reload_ctrl.sv
`timescale 1ns/1ps
module pwm_reload_ctrl
  import pwm_reload_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = $clog2(N_CH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [N_CH-1:0]   match_o,
  output logic [N_CH-1:0]   pwm_o
);
  logic                       load, wrap, en;
  logic [N_CH-1:0]            sel;
  logic [CNT_W-1:0]           mod_buf, init_buf;
  logic [N_CH-1:0][CNT_W-1:0] cv_buf;

  pwm_shadow_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .load_i     (load),
    .rdata_o,
    .mod_buf_o  (mod_buf),
    .init_buf_o (init_buf),
    .cv_buf_o   (cv_buf),
    .sel_o      (sel),
    .en_o       (en)
  );

  pwm_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni,
    .load_i     (load),
    .mod_buf_i  (mod_buf),
    .init_buf_i (init_buf),
    .cnt_o,
    .wrap_o     (wrap)
  );

  for (genvar j = 0; j < N_CH; j++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) i_ch (
      .clk_i, .rst_ni,
      .load_i   (load),
      .cv_buf_i (cv_buf[j]),
      .cnt_i    (cnt_o),
      .match_o  (match_o[j]),
      .pwm_o    (pwm_o[j])
    );
  end

  pwm_load_trig #(.N_CH(N_CH)) i_trig (
    .en_i    (en),
    .wrap_i  (wrap),
    .match_i (match_o),
    .sel_i   (sel),
    .load_o  (load)
  );
endmodule

// File: tb/test_pwm_reload_ctrl.sv
`timescale 1ns/1ps
module test_pwm_reload_ctrl;
  localparam logic [3:0] A_MOD = 4'd0, A_INIT = 4'd1, A_LOAD = 4'd2, A_CV = 4'd8;

  typedef struct packed {
    logic [3:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VEC [0:11] = '{
    '{A_MOD,      32'hFFFF_0009, 32'h0000_0009},
    '{A_INIT,     32'h1234_0002, 32'h0000_0002},
    '{A_CV + 4'd0, 32'h0000_0005, 32'h0000_0005},
    '{A_CV + 4'd1, 32'h0000_0003, 32'h0000_0003},
    '{A_CV + 4'd2, 32'h0000_0020, 32'h0000_0020},
    '{A_CV + 4'd3, 32'h0000_0020, 32'h0000_0020},
    '{A_CV + 4'd4, 32'h0000_0020, 32'h0000_0020},
    '{A_CV + 4'd5, 32'h0000_0020, 32'h0000_0020},
    '{A_CV + 4'd6, 32'h0000_0020, 32'h0000_0020},
    '{A_CV + 4'd7, 32'h0000_0008, 32'h0000_0008},
    '{A_LOAD,     32'hFFFF_FDFF, 32'h0000_00FF},
    '{A_LOAD,     32'h0000_0100, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] cnt_o;
  logic [7:0]  match_o, pwm_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pwm_reload_ctrl i_pwm_reload_ctrl (
    .clk_i (clk), .rst_ni, .we_i, .addr_i, .wdata_i,
    .rdata_o, .cnt_o, .match_o, .pwm_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic wait_cnt(input logic [15:0] v, input string req);
    bit hit = 1'b0;
    for (int i = 0; i < 40 && !hit; i++) begin
      if (cnt_o == v) hit = 1'b1;
      else @(negedge clk);
    end
    chk(req, {31'd0, hit}, 32'd1);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    step(3);
    rst_ni = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 cnt", {16'd0, cnt_o}, 32'd0);
    rd(A_LOAD, r);        chk("R1 load reg", r, 32'd0);
    rd(A_MOD, r);         chk("R1 mod", r, 32'd0);
    rd(A_CV + 4'd3, r);   chk("R1 cv3", r, 32'd0);
    chk("R1 match", {24'd0, match_o}, 32'h0000_00FF);
    chk("R1 pwm", {24'd0, pwm_o}, 32'd0);

    // R3 / R4 table: write then read back the shadow copy
    for (int i = 0; i < 12; i++) begin
      wr(VEC[i].a, VEC[i].d);
      rd(VEC[i].a, r);
      chk((VEC[i].a == A_LOAD) ? "R4 load reg" : "R3 readback", r, VEC[i].e);
    end
    rd(4'd3, r); chk("R3 unmapped", r, 32'd0);

    // R5 nothing active changed without enable
    chk("R5 cnt held", {16'd0, cnt_o}, 32'd0);
    chk("R5 pwm held", {24'd0, pwm_o}, 32'd0);

    // R6 wrap-triggered copy (counter sits at modulus 0)
    wr(A_LOAD, 32'h0000_0200);
    rd(A_LOAD, r); chk("R4 enable set", r, 32'h0000_0200);
    step(1);
    rd(A_LOAD, r); chk("R9 enable cleared", r, 32'd0);
    chk("R6 old start used", {16'd0, cnt_o}, 32'd0);
    chk("R10 pwm at 0", {24'd0, pwm_o}, 32'h0000_00FF);
    chk("R10 match at 0", {24'd0, match_o}, 32'd0);
    step(5);
    chk("R2 cnt 5", {16'd0, cnt_o}, 32'd5);
    chk("R10 match at 5", {24'd0, match_o}, 32'h0000_0001);
    chk("R10 pwm at 5", {24'd0, pwm_o}, 32'h0000_00FC);
    step(4);
    chk("R6 reaches new mod", {16'd0, cnt_o}, 32'd9);
    chk("R10 pwm at 9", {24'd0, pwm_o}, 32'h0000_007C);
    step(1);
    chk("R2 reload start", {16'd0, cnt_o}, 32'd2);

    // R5 shadow write without enable leaves the sequence alone
    wr(A_MOD, 32'd4);
    wait_cnt(16'd9, "R5 old mod still active");
    step(1);
    chk("R5 wrap at 9", {16'd0, cnt_o}, 32'd2);

    // R7 selected channel 0 hit at 5 triggers the copy
    wr(A_MOD, 32'd7);
    wait_cnt(16'd2, "R7 sync");
    wr(A_LOAD, 32'h0000_0201);
    rd(A_LOAD, r); chk("R7 armed", r, 32'h0000_0201);
    step(2);
    chk("R7 at hit", {24'd0, match_o}, 32'h0000_0001);
    step(1);
    chk("R7 cnt after hit", {16'd0, cnt_o}, 32'd6);
    rd(A_LOAD, r); chk("R9 cleared by hit, mask kept", r, 32'h0000_0001);
    step(1);
    chk("R7 cnt 7", {16'd0, cnt_o}, 32'd7);
    step(1);
    chk("R7 new mod 7 used", {16'd0, cnt_o}, 32'd2);

    // R8 unselected hits (ch0 at 5, ch1 at 3) must not trigger
    wr(A_MOD, 32'd9);
    wr(A_CV + 4'd7, 32'd9);
    wait_cnt(16'd2, "R8 sync");
    wr(A_LOAD, 32'h0000_0204);
    step(3);
    chk("R8 cnt 6", {16'd0, cnt_o}, 32'd6);
    rd(A_LOAD, r); chk("R8 enable survives masked hits", r, 32'h0000_0204);
    step(1);
    chk("R8 mod still 7", {16'd0, cnt_o}, 32'd7);
    step(1);
    chk("R6 wrap copy", {16'd0, cnt_o}, 32'd2);
    rd(A_LOAD, r); chk("R9 cleared by wrap", r, 32'h0000_0004);
    step(7);
    chk("R6 mod 9 active", {16'd0, cnt_o}, 32'd9);

    // R9 wrap and ch7 hit coincide at 9: one copy
    wr(A_MOD, 32'd6);
    wait_cnt(16'd2, "R9 sync");
    wr(A_LOAD, 32'h0000_0280);
    wait_cnt(16'd9, "R9 reach 9");
    chk("R9 coincident hit", {24'd0, match_o}, 32'h0000_0080);
    step(1);
    chk("R9 restart", {16'd0, cnt_o}, 32'd2);
    rd(A_LOAD, r); chk("R9 single clear", r, 32'h0000_0080);
    step(4);
    chk("R9 cnt 6", {16'd0, cnt_o}, 32'd6);
    step(1);
    chk("R9 mod 6 active", {16'd0, cnt_o}, 32'd2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule